// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers up to 64 level-sensitive interrupt request lines. It steers each line through a per-source configuration word to a normal interrupt output, a fast interrupt output, or both. A second bank of per-source words holds enables for extra cores. Each extra core has its own interrupt output, and that output is driven only from the second bank.

Software reads a single selection word to learn whether any routed source is active and, if so, which one. When several are active, the lowest-numbered one is reported. Nothing is latched: every output and the selection word follow the request inputs and the stored configuration combinationally. An interrupt therefore goes away as soon as its request line drops or its routing is cleared.

A parameter picks one of two layouts for the configuration word. The routed layout keeps only two route bits. The legacy layout keeps a 7-bit control field and uses another selection address. Register access is a single-cycle word-addressed port. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `irq_route_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stored configuration bit in both banks, so all outputs are low and every register reads zero afterwards, even with all requests high.
- R2: Word address n (byte 4n, n < 64) holds the configuration of source n. Word address 0x80+n holds the core-enable word of source n. The selection word is at word 0x41 in the routed layout and at word 0x43 in the legacy layout. Any other address reads zero and ignores writes.
- R3: In the routed layout, configuration bit 5 routes a source to `irq_o` and bit 6 routes it to `fiq_o`. Only these two bits are stored, and every other bit reads back as zero (writing 0xFFFFFFFF reads back 0x60).
- R4: In the legacy layout, bits 6:0 are stored and read back (writing 0xFF reads back 0x7F). Bit 6 routes to `irq_o`, bit 5 routes to `fiq_o`, and the value 0x51 routes to `irq_o` only.
- R5: Sources are level-sensitive. An output rises in the same cycle as a routed request line and falls in the same cycle when that line drops, with no clock edge needed.
- R6: `irq_o` is the OR of all active sources whose IRQ route bit is set. `fiq_o` is the OR of all active sources whose FIQ route bit is set.
- R7: A source is pending when its request is high and at least one of its route bits is set. The selection word has bit 6 set when any source is pending, and bits 5:0 hold the lowest pending source number.
- R8: When no source is pending, the whole selection word reads zero, even if unrouted requests are high.
- R9: Bits 7:4 of a core-enable word are stored and all other bits read zero. `core_irq_o[k]` is the OR of the active sources whose core-enable bit 4+k is set, independent of the IRQ and FIQ routing.
- R10: Writes to the selection word have no effect on any stored configuration or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level request lines, one per source |
| reg_addr | input | 8 | Word address of the register access |
| reg_we | input | 1 | Write enable, acted on at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| core_irq_o | output | 4 | Interrupt outputs for the extra cores |

## Verification
The assertions assume that the request lines are synchronous to `clk`. They also assume that the request lines and the register port are driven to known values from the first edge onwards. The bench meets both assumptions by changing every input only at the falling edge and by holding reset over the first edges. The picker and idle-selection properties take for granted that a pending source always has a route bit set. The stimulus creates pending sources only by writing route bits through the register port, never by any other path.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic {
        LAYOUT_LEGACY = 1'b0,
        LAYOUT_ROUTED = 1'b1
    } layout_e;

    localparam int CTL_W       = 7;
    localparam int ADDR_W      = 8;
    localparam int SEL_IDX_W   = 6;
    localparam int CORE_LSB    = 4;
    localparam logic [ADDR_W-1:0] CORE_BANK_BASE = 8'h80;

    typedef struct packed {
        logic                 pend;
        logic [SEL_IDX_W-1:0] idx;
    } sel_t;

    function automatic logic [CTL_W-1:0] ctl_mask(layout_e l);
        return (l == LAYOUT_ROUTED) ? 7'h60 : 7'h7f;
    endfunction

    function automatic int irq_pos(layout_e l);
        return (l == LAYOUT_ROUTED) ? 5 : 6;
    endfunction

    function automatic int fiq_pos(layout_e l);
        return (l == LAYOUT_ROUTED) ? 6 : 5;
    endfunction

    function automatic logic [ADDR_W-1:0] sel_word(layout_e l);
        return (l == LAYOUT_ROUTED) ? 8'h41 : 8'h43;
    endfunction

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
    import irq_route_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCORE = 4,
    parameter logic [CTL_W-1:0] CTL_MASK = 7'h60
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [31:0]                       wdata,
    output logic [NSRC-1:0][CTL_W-1:0]        ctl_q,
    output logic [NSRC-1:0][NCORE-1:0]        core_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(i);
        localparam logic [ADDR_W-1:0] CORE_ADDR = CORE_BANK_BASE + ADDR_W'(i);
        logic [CTL_W-1:0] ctl_r;
        logic [NCORE-1:0] core_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_r  <= '0;
                core_r <= '0;
            end else if (we) begin
                if (addr == CTL_ADDR)
                    ctl_r <= wdata[CTL_W-1:0] & CTL_MASK;
                if (addr == CORE_ADDR)
                    core_r <= wdata[CORE_LSB +: NCORE];
            end
        end

        assign ctl_q[i]  = ctl_r;
        assign core_q[i] = core_r;
    end

endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
    import irq_route_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCORE = 4,
    parameter int IRQ_POS = 5,
    parameter int FIQ_POS = 6
) (
    input  logic [NSRC-1:0]                src,
    input  logic [NSRC-1:0][CTL_W-1:0]     ctl,
    input  logic [NSRC-1:0][NCORE-1:0]     core_en,
    output logic                           irq,
    output logic                           fiq,
    output logic [NCORE-1:0]               core_irq,
    output logic [NSRC-1:0]                act
);

    always_comb begin
        irq      = 1'b0;
        fiq      = 1'b0;
        core_irq = '0;
        act      = '0;
        for (int i = 0; i < NSRC; i++) begin
            act[i]   = src[i] & (ctl[i][IRQ_POS] | ctl[i][FIQ_POS]);
            irq      = irq | (src[i] & ctl[i][IRQ_POS]);
            fiq      = fiq | (src[i] & ctl[i][FIQ_POS]);
            core_irq = core_irq | ({NCORE{src[i]}} & core_en[i]);
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC = 64,
    parameter int IDX_W = 6
) (
    input  logic [NSRC-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i])
                idx = IDX_W'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCORE = 4,
    parameter layout_e LAYOUT = LAYOUT_ROUTED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [NCORE-1:0]  core_irq_o
);

    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [CTL_W-1:0]  MASK = ctl_mask(LAYOUT);
    localparam logic [ADDR_W-1:0] SEL_ADDR = sel_word(LAYOUT);

    logic [NSRC-1:0][CTL_W-1:0] ctl_q;
    logic [NSRC-1:0][NCORE-1:0] core_q;
    logic [NSRC-1:0]            act_vec;
    logic                       pick_any;
    logic [IDX_W-1:0]           pick_idx;
    sel_t                       sel;

    irq_cfg_bank #(.NSRC(NSRC), .NCORE(NCORE), .CTL_MASK(MASK)) u_bank (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .ctl_q(ctl_q), .core_q(core_q)
    );

    irq_route_merge #(.NSRC(NSRC), .NCORE(NCORE),
                      .IRQ_POS(irq_pos(LAYOUT)), .FIQ_POS(fiq_pos(LAYOUT))) u_merge (
        .src(src_i), .ctl(ctl_q), .core_en(core_q),
        .irq(irq_o), .fiq(fiq_o), .core_irq(core_irq_o), .act(act_vec)
    );

    irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .req(act_vec), .any(pick_any), .idx(pick_idx)
    );

    always_comb begin
        sel.pend = pick_any;
        sel.idx  = SEL_IDX_W'(pick_idx);
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NSRC) begin
            reg_rdata[CTL_W-1:0] = ctl_q[reg_addr[IDX_W-1:0]];
        end else if (reg_addr >= CORE_BANK_BASE &&
                     int'(reg_addr) < int'(CORE_BANK_BASE) + NSRC) begin
            reg_rdata[CORE_LSB +: NCORE] = core_q[IDX_W'(reg_addr - CORE_BANK_BASE)];
        end else if (reg_addr == SEL_ADDR) begin
            reg_rdata[SEL_IDX_W:0] = sel;
        end
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NSRC = 64,
    parameter int NCORE = 4,
    parameter int IDX_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_i,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [NCORE-1:0]  core_irq_o,
    input logic [NSRC-1:0]   act_vec,
    input logic              pick_any,
    input logic [IDX_W-1:0]  pick_idx
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq_o && !fiq_o && core_irq_o == '0));

    p_no_request_no_output_r5: assert property (@(posedge clk) disable iff (rst)
        (src_i == '0) |-> (!irq_o && !fiq_o && core_irq_o == '0));

    p_route_implies_pending_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_o || fiq_o) |-> pick_any);

    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
        pick_any |-> (act_vec[pick_idx] &&
                      ((act_vec & ((NSRC'(1) << pick_idx) - NSRC'(1))) == '0)));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !pick_any |-> (pick_idx == '0 && !irq_o && !fiq_o));

endmodule

bind irq_route_ctrl irq_route_chk #(.NSRC(NSRC), .NCORE(NCORE), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o),
    .core_irq_o(core_irq_o), .act_vec(act_vec), .pick_any(pick_any),
    .pick_idx(pick_idx)
);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
    import irq_route_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    logic [3:0]  cirq;

    logic [63:0] l_src = '0;
    logic [7:0]  l_addr = '0;
    logic        l_we = 1'b0;
    logic [31:0] l_wdata = '0;
    logic [31:0] l_rdata;
    logic        l_irq, l_fiq;
    logic [3:0]  l_cirq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_ctrl #(.NSRC(64), .NCORE(4), .LAYOUT(LAYOUT_ROUTED)) u_dut (
        .clk(clk), .rst(rst), .src_i(src), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .fiq_o(fiq),
        .core_irq_o(cirq)
    );

    irq_route_ctrl #(.NSRC(64), .NCORE(4), .LAYOUT(LAYOUT_LEGACY)) u_dut_leg (
        .clk(clk), .rst(rst), .src_i(l_src), .reg_addr(l_addr), .reg_we(l_we),
        .reg_wdata(l_wdata), .reg_rdata(l_rdata), .irq_o(l_irq), .fiq_o(l_fiq),
        .core_irq_o(l_cirq)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [31:0] d;
        logic [63:0] s;
        logic        ei;
        logic        ef;
        logic [31:0] esel;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'd3,  32'h20,       64'h8,                    1'b1, 1'b0, 32'h43},
        '{8'd10, 32'h40,       64'h408,                  1'b1, 1'b1, 32'h43},
        '{8'd63, 32'h60,       64'h8000_0000_0000_0000,  1'b1, 1'b1, 32'h7F},
        '{8'd3,  32'h00,       64'h408,                  1'b0, 1'b1, 32'h4A},
        '{8'd0,  32'h20,       64'h20,                   1'b0, 1'b0, 32'h00},
        '{8'd0,  32'h20,       64'h8000_0000_0000_0001,  1'b1, 1'b1, 32'h40},
        '{8'd5,  32'hFFFF_FFFF, 64'h420,                 1'b1, 1'b1, 32'h45},
        '{8'd20, 32'h20,       64'h0,                    1'b0, 1'b0, 32'h00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic lwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        l_addr = a; l_wdata = d; l_we = 1'b1;
        @(negedge clk);
        l_we = 1'b0;
    endtask

    task automatic lrd(input logic [7:0] a, output logic [31:0] d);
        l_addr = a;
        #1 d = l_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state with all requests high
        src = '1;
        rd(8'd0, v);   chk("R1 cfg0", v, 0);
        rd(8'd63, v);  chk("R1 cfg63", v, 0);
        rd(8'h80, v);  chk("R1 core0", v, 0);
        rd(8'h41, v);  chk("R1 sel", v, 0);
        chk("R1 outputs", {irq, fiq, cirq}, 0);
        src = '0;

        // R6 R7 R8: table walk
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].a, VECS[i].d);
            src = VECS[i].s;
            rd(8'h41, v);
            chk("R6 irq", irq, VECS[i].ei);
            chk("R6 fiq", fiq, VECS[i].ef);
            chk("R7 R8 sel", v, VECS[i].esel);
        end

        // R3: readback of routed layout
        rd(8'd5, v);   chk("R3 readback", v, 32'h60);
        rd(8'd10, v);  chk("R3 fiq only", v, 32'h40);
        // R2: unmapped address
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, v);  chk("R2 unmapped", v, 0);
        rd(8'h43, v);  chk("R2 legacy sel word unmapped", v, 0);

        // R10: selection write ignored
        src = '0;
        wr(8'h41, 32'hFFFF_FFFF);
        rd(8'h41, v);  chk("R10 sel", v, 0);
        rd(8'd1, v);   chk("R10 cfg1", v, 0);
        rd(8'd3, v);   chk("R10 cfg3", v, 0);
        chk("R10 outputs", {irq, fiq, cirq}, 0);

        // R5: level behaviour without clock
        wr(8'd3, 32'h20);
        @(negedge clk);
        src = 64'h8;
        #1 chk("R5 rise", irq, 1);
        src = 64'h0;
        #1 chk("R5 fall", irq, 0);

        // R9: core bank
        wr(8'h87, 32'hFFFF_FFFF);
        rd(8'h87, v);  chk("R9 readback", v, 32'hF0);
        src = 64'h80;
        #1 chk("R9 core all", cirq, 4'hF);
        chk("R9 no main route", irq, 0);
        wr(8'h89, 32'h20);
        wr(8'h87, 32'h0);
        src = 64'h280;
        #1 chk("R9 core1 only", cirq, 4'b0010);
        rd(8'h41, v);  chk("R9 sel unaffected", v, 0);
        src = '0;

        // R4: legacy layout
        lwr(8'd2, 32'h51);
        lrd(8'd2, v);  chk("R4 readback 51", v, 32'h51);
        l_src = 64'h4;
        #1 chk("R4 irq", {l_irq, l_fiq}, 2'b10);
        lrd(8'h43, v); chk("R4 R2 sel", v, 32'h42);
        lrd(8'h41, v); chk("R2 legacy 0x41", v, 0);
        lwr(8'd2, 32'hFF);
        lrd(8'd2, v);  chk("R4 readback 7f", v, 32'h7F);
        #1 chk("R4 both", {l_irq, l_fiq}, 2'b11);
        lwr(8'd2, 32'h00);
        #1 chk("R4 disable", {l_irq, l_fiq}, 2'b00);
        l_src = '0;

        // R1: reset mid-run clears everything
        src = '1;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(8'd5, v);   chk("R1 re-reset cfg5", v, 0);
        rd(8'h89, v);  chk("R1 re-reset core9", v, 0);
        chk("R1 re-reset outputs", {irq, fiq, cirq}, 0);
        src = '0;

        finish_run();
    end

endmodule